// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the 16-bit processor status word of a 16-bit datapath and derives its arithmetic flags from each ALU or shifter result. Every cycle the execution stage can present an update: a result with an 8-bit or 16-bit width select, the adder carry-out, a signed-overflow indication, an auxiliary carry computed elsewhere, the bit shifted out by a logical shift, and a 3-bit operation class. The class decides which flags move. Register and memory transfers and the bitwise complement leave the word untouched.

To save the status word, the stack path reads the registered word directly from `psw`. To restore it, the stack path asserts `pop_en` with the word read back, and the unit loads all live bits at once. The trap-enable, interrupt-enable and direction control flags can only change through that restore path. They are also brought out as separate outputs for the sequencer and the string unit. Nine bit positions are live. The other seven always read as zero.

Top module: `psw_unit`

## Requirements
- R1: After reset, `psw` reads 16'h0000.
- R2: Bits 1, 3, 5, 12, 13, 14 and 15 of `psw` always read 0, even after a restore of 16'hFFFF. The live mask is 16'h0FD5.
- R3: On an update of class arithmetic (1), logic (2) or shift (4), the zero flag (bit 6) is set if the selected width of `result` is all zero. It is cleared otherwise. With `wide`=0 only bits 7:0 count; with `wide`=1 all 16 bits count.
- R4: On those classes, the sign flag (bit 7) takes `result[15]` when `wide`=1 and `result[7]` when `wide`=0.
- R5: On those classes, the parity flag (bit 2) is 1 when `result[7:0]` has an even number of one bits, whatever the width.
- R6: On class arithmetic (1), the carry flag (bit 0) takes `carry_in`, the overflow flag (bit 11) takes `ovf_in`, and the auxiliary flag (bit 4) takes `af_in`.
- R7: On class logic (2), the carry, overflow and auxiliary flags are cleared.
- R8: On class shift (4), the carry flag takes `shift_out` and the overflow flag takes `ovf_in`. The auxiliary flag keeps its value.
- R9: Class move (0), class complement (3), classes 5 to 7, and any cycle with `upd_en`=0 leave `psw` unchanged.
- R10: Trap (bit 8), interrupt-enable (bit 9) and direction (bit 10) change only on a restore. `tf_o`, `if_o` and `df_o` always equal those bits.
- R11: `pop_en` loads `pop_word` masked by 16'h0FD5 into `psw`, visible after the next clock edge.
- R12: When `pop_en` and `upd_en` are both high in one cycle, the restore wins and the update is discarded.
- R13: Every change to `psw` takes effect one clock edge after its inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Flag update request this cycle |
| op_cls | input | 3 | Operation class: 0 move, 1 arithmetic, 2 logic, 3 complement, 4 shift |
| wide | input | 1 | 1 = 16-bit result, 0 = 8-bit result |
| result | input | 16 | ALU or shifter result |
| carry_in | input | 1 | Adder carry-out of the top bit |
| ovf_in | input | 1 | Signed overflow indication |
| af_in | input | 1 | Auxiliary carry from the ALU |
| shift_out | input | 1 | Last bit shifted out by a logical shift |
| pop_en | input | 1 | Restore the status word from `pop_word` |
| pop_word | input | 16 | Word read back from the stack |
| psw | output | 16 | Registered status word, also the value to push |
| tf_o | output | 1 | Trap flag |
| if_o | output | 1 | Interrupt-enable flag |
| df_o | output | 1 | Direction flag |

## Verification
A restore and a flag update can arrive in the same cycle. This happens when a restore retires while an arithmetic result is also presented. The bench provokes it by driving `pop_en` together with an arithmetic update whose result and carry would produce a clearly different word. It then judges that the word after the edge matches the masked restore word exactly. The bench also places a restore directly before an arithmetic update, to show that the control bits loaded by the restore survive the update that follows.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam int B_CF = 0;
    localparam int B_PF = 2;
    localparam int B_AF = 4;
    localparam int B_ZF = 6;
    localparam int B_SF = 7;
    localparam int B_TF = 8;
    localparam int B_IF = 9;
    localparam int B_DF = 10;
    localparam int B_OF = 11;

    localparam logic [WORD_W-1:0] LIVE_MASK =
        WORD_W'((1 << B_CF) | (1 << B_PF) | (1 << B_AF) | (1 << B_ZF) |
                (1 << B_SF) | (1 << B_TF) | (1 << B_IF) | (1 << B_DF) |
                (1 << B_OF));

    typedef enum logic [2:0] {
        CLS_MOVE  = 3'd0,
        CLS_ARITH = 3'd1,
        CLS_LOGIC = 3'd2,
        CLS_COMPL = 3'd3,
        CLS_SHIFT = 3'd4,
        CLS_RSV5  = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } op_cls_e;

endpackage

// File: rtl/psw_result_flags.sv
module psw_result_flags #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic         wide,
    input  logic [W-1:0] result,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    logic narrow_zero;
    logic full_zero;

    always_comb begin
        narrow_zero = (result[BW-1:0] == '0);
        full_zero   = (result == '0);
        zf          = wide ? full_zero : narrow_zero;
        sf          = wide ? result[W-1] : result[BW-1];
        // even number of ones in the low byte
        pf          = ~(^result[BW-1:0]);
    end
endmodule

// File: rtl/psw_next.sv
module psw_next
    import psw_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic              upd_en,
    input  op_cls_e           cls,
    input  logic              zf,
    input  logic              sf,
    input  logic              pf,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic              af_in,
    input  logic              shift_out,
    input  logic              pop_en,
    input  logic [WORD_W-1:0] pop_word,
    output logic [WORD_W-1:0] nxt
);
    logic [WORD_W-1:0] upd;

    always_comb begin
        upd = cur;
        unique case (cls)
            CLS_ARITH: begin
                upd[B_ZF] = zf;
                upd[B_SF] = sf;
                upd[B_PF] = pf;
                upd[B_CF] = carry_in;
                upd[B_OF] = ovf_in;
                upd[B_AF] = af_in;
            end
            CLS_LOGIC: begin
                upd[B_ZF] = zf;
                upd[B_SF] = sf;
                upd[B_PF] = pf;
                upd[B_CF] = 1'b0;
                upd[B_OF] = 1'b0;
                upd[B_AF] = 1'b0;
            end
            CLS_SHIFT: begin
                upd[B_ZF] = zf;
                upd[B_SF] = sf;
                upd[B_PF] = pf;
                upd[B_CF] = shift_out;
                upd[B_OF] = ovf_in;
            end
            default: upd = cur;
        endcase

        if (pop_en)
            nxt = pop_word & LIVE_MASK;
        else if (upd_en)
            nxt = upd & LIVE_MASK;
        else
            nxt = cur;
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_en,
    input  logic [2:0]  op_cls,
    input  logic        wide,
    input  logic [15:0] result,
    input  logic        carry_in,
    input  logic        ovf_in,
    input  logic        af_in,
    input  logic        shift_out,
    input  logic        pop_en,
    input  logic [15:0] pop_word,
    output logic [15:0] psw,
    output logic        tf_o,
    output logic        if_o,
    output logic        df_o
);
    logic [WORD_W-1:0] psw_q;
    logic [WORD_W-1:0] psw_d;
    logic              zf_c, sf_c, pf_c;
    op_cls_e           cls;

    assign cls = op_cls_e'(op_cls);

    psw_result_flags #(.W(WORD_W), .BW(BYTE_W)) u_flags (
        .wide   (wide),
        .result (result),
        .zf     (zf_c),
        .sf     (sf_c),
        .pf     (pf_c)
    );

    psw_next u_next (
        .cur       (psw_q),
        .upd_en    (upd_en),
        .cls       (cls),
        .zf        (zf_c),
        .sf        (sf_c),
        .pf        (pf_c),
        .carry_in  (carry_in),
        .ovf_in    (ovf_in),
        .af_in     (af_in),
        .shift_out (shift_out),
        .pop_en    (pop_en),
        .pop_word  (pop_word),
        .nxt       (psw_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) psw_q <= '0;
        else        psw_q <= psw_d;
    end

    always_comb begin
        psw  = psw_q;
        tf_o = psw_q[B_TF];
        if_o = psw_q[B_IF];
        df_o = psw_q[B_DF];
    end

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psw & ~LIVE_MASK) == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_en && (!upd_en || op_cls == 3'd0 || op_cls == 3'd3 || op_cls > 3'd4))
        |=> $stable(psw));

    p_ctrl_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> $stable(psw[B_DF:B_TF]));

    p_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> psw == ($past(pop_word) & LIVE_MASK));

    p_arith_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_en && upd_en && op_cls == 3'd1)
        |=> (psw[B_CF] == $past(carry_in)) && (psw[B_OF] == $past(ovf_in)));

    p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_en && upd_en && op_cls == 3'd2)
        |=> !psw[B_CF] && !psw[B_OF] && !psw[B_AF]);

    p_shift_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_en && upd_en && op_cls == 3'd4)
        |=> (psw[B_CF] == $past(shift_out)) && $stable(psw[B_AF]));
endmodule

// File: tb/psw_unit_bench.sv
`timescale 1ns/1ps
module psw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  op_cls = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] result = '0;
    logic        carry_in = 1'b0, ovf_in = 1'b0, af_in = 1'b0, shift_out = 1'b0;
    logic        pop_en = 1'b0;
    logic [15:0] pop_word = '0;
    logic [15:0] psw;
    logic        tf_o, if_o, df_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] model = '0;
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    psw_unit u_psw_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls), .wide(wide),
        .result(result), .carry_in(carry_in), .ovf_in(ovf_in), .af_in(af_in),
        .shift_out(shift_out), .pop_en(pop_en), .pop_word(pop_word),
        .psw(psw), .tf_o(tf_o), .if_o(if_o), .df_o(df_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // bench model of the flag rules, written from the requirements
    function automatic logic [15:0] predict(input logic [15:0] cur, input bit up,
        input logic [2:0] c, input bit w, input logic [15:0] r, input bit cy,
        input bit ov, input bit ax, input bit so, input bit pp, input logic [15:0] pw);
        logic [15:0] n;
        n = cur;
        if (pp) return pw & 16'h0FD5;
        if (!up) return cur;
        if (c == 3'd1 || c == 3'd2 || c == 3'd4) begin
            n[6] = w ? (r == 16'h0) : (r[7:0] == 8'h0);
            n[7] = w ? r[15] : r[7];
            n[2] = ($countones(r[7:0]) % 2) == 0;
            if (c == 3'd1) begin n[0] = cy; n[11] = ov; n[4] = ax; end
            if (c == 3'd2) begin n[0] = 0; n[11] = 0; n[4] = 0; end
            if (c == 3'd4) begin n[0] = so; n[11] = ov; end
        end
        return n;
    endfunction

    task automatic drive(input string tag, input bit up, input logic [2:0] c,
        input bit w, input logic [15:0] r, input bit cy, input bit ov, input bit ax,
        input bit so, input bit pp, input logic [15:0] pw);
        @(negedge clk);
        upd_en = up; op_cls = c; wide = w; result = r; carry_in = cy;
        ovf_in = ov; af_in = ax; shift_out = so; pop_en = pp; pop_word = pw;
        model = predict(model, up, c, w, r, cy, ov, ax, so, pp, pw);
        q_exp.push_back(model);
        q_tag.push_back(tag);
    endtask

    // monitor: pops one expected word per edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                logic [15:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, psw, e);
                check({t, " R10 ctrl outs"}, {13'd0, df_o, if_o, tf_o}, {13'd0, e[10:8]});
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", psw, 16'h0000);

        drive("R3 R5 R6 arith16 zero carry", 1, 3'd1, 1, 16'h0000, 1, 0, 1, 0, 0, 0);
        drive("R3 R13 arith8 low byte zero", 1, 3'd1, 0, 16'hFF00, 0, 0, 0, 0, 0, 0);
        drive("R4 R5 R6 arith16 negative ovf", 1, 3'd1, 1, 16'h8001, 0, 1, 0, 0, 0, 0);
        drive("R4 arith8 sign from bit7", 1, 3'd1, 0, 16'h0080, 1, 0, 0, 0, 0, 0);
        drive("R7 logic clears cf of af", 1, 3'd2, 1, 16'h1234, 1, 1, 1, 0, 0, 0);
        drive("R9 complement class holds", 1, 3'd3, 1, 16'h0000, 1, 1, 1, 1, 0, 0);
        drive("R9 move class holds", 1, 3'd0, 1, 16'h0000, 1, 1, 1, 1, 0, 0);
        drive("R9 upd_en low holds", 0, 3'd1, 1, 16'h0000, 1, 1, 1, 1, 0, 0);
        drive("R9 reserved class holds", 1, 3'd6, 1, 16'h0000, 1, 1, 1, 1, 0, 0);
        drive("R8 R5 shift carry", 1, 3'd4, 1, 16'h0003, 0, 0, 1, 1, 0, 0);
        drive("R2 R11 restore all ones", 0, 3'd0, 0, 16'h0, 0, 0, 0, 0, 1, 16'hFFFF);
        drive("R10 arith keeps ctrl", 1, 3'd1, 1, 16'h0001, 0, 0, 0, 0, 0, 0);
        drive("R8 shift keeps af", 1, 3'd4, 0, 16'h00F0, 0, 1, 0, 0, 0, 0);
        drive("R12 restore beats update", 1, 3'd1, 1, 16'h0000, 1, 1, 1, 0, 1, 16'h0001);
        drive("R11 restore clears ctrl", 0, 3'd0, 0, 16'h0, 0, 0, 0, 0, 1, 16'hF02A);
        drive("R3 arith16 nonzero high", 1, 3'd1, 1, 16'h0100, 0, 0, 0, 0, 0, 0);
        drive("R9 idle", 0, 3'd0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule